// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block lays a small square cursor image over a stream of display pixels. For every raster position it receives the incoming RGB value. The output is the same RGB value, a cursor colour, or the bitwise inverse of the screen pixel. The choice depends on two bitmap planes, a mask plane and a toggle plane, which together give each cursor pixel one of four meanings. The composited result leaves the block one clock cycle after its pixel entered.

The host programs the block through a byte-wide write port with a 4-bit register select:

- **Bitmap memory.** The host sets a bitmap address, then streams bytes through a data port. The address steps forward after every byte. A control bit chooses which plane receives the bytes.
- **Cursor colours.** There are three colour slots. Each slot is filled one component at a time, in red, green, blue order.
- **Cursor position.** The host writes the position as low and high bytes into a shadow copy. The shadow copy reaches the live position only while the retrace input is high, so a move never tears a visible frame. The position is biased by the cursor size, which lets the cursor hang partly off the left or top edge of the screen.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor is disabled, both live coordinates are 0 and `out_rgb` carries each `pix_rgb` value one cycle after it was presented.
- R2: While the enable bit (bit 0 of the control register, select 3) is 0, every pixel passes through unchanged with one cycle of latency.
- R3: A pixel whose screen coordinate falls outside the cursor square passes through unchanged with one cycle of latency.
- R4: With live position (X, Y) and cursor size D, cursor column c and row r appear at screen x = X - D + c and y = Y - D + r. Parts that fall below screen coordinate 0 are simply not shown.
- R5: Each cursor pixel is decoded from its mask bit M and toggle bit T as follows. M=1, T=0 gives the screen pixel. M=1, T=1 gives the bitwise inverse of all 24 screen bits. M=0, T=0 gives colour slot 0. M=0, T=1 gives colour slot 1.
- R6: The bitmap byte address within a plane is set through select 0 (low byte) and select 1 (high byte). Row r, byte b sits at address r*(D/8)+b, and bit 7 of each byte is its leftmost pixel. Each write to the data port (select 2) stores one byte and then advances the address by one, wrapping from the last byte of the plane to 0.
- R7: Control bit 1 steers data-port writes to the mask plane when 0 and to the toggle plane when 1.
- R8: Writes to X (select 6 low byte, select 7 high byte) and Y (selects 8 and 9) go to a shadow copy. The shadow copy is loaded into the live position on every cycle in which `retrace` is 1, and takes effect from the next pixel.
- R9: Writing select 4 chooses colour slot 0, 1 or 2 (any other value selects slot 0) and restarts at red. Each write to select 5 fills red, then green, then blue. After blue, the slot advances, wrapping from slot 2 to slot 0.
- R10: Writes to selects 10 to 15 change nothing visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 4 | Register select |
| host_wdata | input | 8 | Register write byte |
| retrace | input | 1 | High while the raster is in retrace; opens the position copy |
| pix_x | input | COORD_W | Raster column of the incoming pixel |
| pix_y | input | COORD_W | Raster row of the incoming pixel |
| pix_rgb | input | 24 | Incoming pixel, red in bits 23:16, blue in bits 7:0 |
| out_rgb | output | 24 | Composited pixel, one cycle later |

## Verification
The bench builds the block with a 16x16 cursor and 10-bit coordinates. Each plane is then only 32 bytes, so the whole bitmap can be loaded, and the address wrap reached, in a few dozen writes. It also means a 48x48 raster sweep covers every cursor pixel together with all four borders. Each sweep compares every output pixel against an arithmetic model built from the requirements. The sweeps run at positions that clip the cursor on the top-left, place it exactly at the origin, hold it fully inside, and push it past the right edge of the swept area.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam int CUR_NUM_COL = 3;

  typedef enum logic [3:0] {
    SEL_BADDR_LO = 4'd0,
    SEL_BADDR_HI = 4'd1,
    SEL_BDATA    = 4'd2,
    SEL_CTRL     = 4'd3,
    SEL_CIDX     = 4'd4,
    SEL_CDATA    = 4'd5,
    SEL_XLO      = 4'd6,
    SEL_XHI      = 4'd7,
    SEL_YLO      = 4'd8,
    SEL_YHI      = 4'd9
  } reg_sel_e;

  typedef enum logic [1:0] {
    PIX_CLEAR  = 2'd0,
    PIX_INVERT = 2'd1,
    PIX_COL0   = 2'd2,
    PIX_COL1   = 2'd3
  } pix_kind_e;

  function automatic pix_kind_e decode_pix(input logic mask_b, input logic tog_b);
    if (mask_b) return tog_b ? PIX_INVERT : PIX_CLEAR;
    return tog_b ? PIX_COL1 : PIX_COL0;
  endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int BADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [3:0]         sel,
  input  logic [7:0]         wdata,
  input  logic               retrace,
  output logic               cur_en,
  output logic               plane_sel,
  output logic               bmp_we,
  output logic [BADDR_W-1:0] bmp_waddr,
  output logic [7:0]         bmp_wdata,
  output rgb_t               col_a,
  output rgb_t               col_b,
  output logic [COORD_W-1:0] live_x,
  output logic [COORD_W-1:0] live_y
);
  localparam int SLOT_W = $clog2(CUR_NUM_COL);

  function automatic logic [BADDR_W-1:0] put_addr_byte(
    input logic [BADDR_W-1:0] cur, input logic hi, input logic [7:0] b);
    logic [15:0] e;
    e = 16'(cur);
    if (hi) e[15:8] = b;
    else    e[7:0]  = b;
    return e[BADDR_W-1:0];
  endfunction

  function automatic logic [COORD_W-1:0] put_pos_byte(
    input logic [COORD_W-1:0] cur, input logic hi, input logic [7:0] b);
    logic [15:0] e;
    e = 16'(cur);
    if (hi) e[15:8] = b;
    else    e[7:0]  = b;
    return e[COORD_W-1:0];
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (32'(s) == CUR_NUM_COL - 1) ? '0 : s + 1'b1;
  endfunction

  reg_sel_e             sel_e;
  logic [BADDR_W-1:0]   baddr;
  logic [COORD_W-1:0]   shadow_x, shadow_y;
  logic [SLOT_W-1:0]    slot;
  logic [2:0]           phase;
  rgb_t                 col [CUR_NUM_COL];
  logic                 data_wr;
  logic                 cdata_wr;

  assign sel_e     = reg_sel_e'(sel);
  assign data_wr   = we && (sel_e == SEL_BDATA);
  assign cdata_wr  = we && (sel_e == SEL_CDATA);
  assign bmp_we    = data_wr;
  assign bmp_waddr = baddr;
  assign bmp_wdata = wdata;
  assign col_a     = col[0];
  assign col_b     = col[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baddr     <= '0;
      cur_en    <= 1'b0;
      plane_sel <= 1'b0;
      shadow_x  <= '0;
      shadow_y  <= '0;
      live_x    <= '0;
      live_y    <= '0;
      slot      <= '0;
      phase     <= 3'b001;
      for (int i = 0; i < CUR_NUM_COL; i++) col[i] <= '0;
    end else begin
      if (retrace) begin
        live_x <= shadow_x;
        live_y <= shadow_y;
      end
      if (we) begin
        case (sel_e)
          SEL_BADDR_LO: baddr <= put_addr_byte(baddr, 1'b0, wdata);
          SEL_BADDR_HI: baddr <= put_addr_byte(baddr, 1'b1, wdata);
          SEL_BDATA:    baddr <= baddr + 1'b1;
          SEL_CTRL: begin
            cur_en    <= wdata[0];
            plane_sel <= wdata[1];
          end
          SEL_CIDX: begin
            slot  <= (32'(wdata) < CUR_NUM_COL) ? wdata[SLOT_W-1:0] : '0;
            phase <= 3'b001;
          end
          SEL_CDATA: begin
            if (phase[0]) col[slot].r <= wdata;
            if (phase[1]) col[slot].g <= wdata;
            if (phase[2]) begin
              col[slot].b <= wdata;
              slot        <= next_slot(slot);
              phase       <= 3'b001;
            end else begin
              phase <= {phase[1:0], 1'b0};
            end
          end
          SEL_XLO: shadow_x <= put_pos_byte(shadow_x, 1'b0, wdata);
          SEL_XHI: shadow_x <= put_pos_byte(shadow_x, 1'b1, wdata);
          SEL_YLO: shadow_y <= put_pos_byte(shadow_y, 1'b0, wdata);
          SEL_YHI: shadow_y <= put_pos_byte(shadow_y, 1'b1, wdata);
          default: ;
        endcase
      end
    end
  end

  // R6: each data-port byte moves the bitmap address on by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> bmp_waddr == BADDR_W'($past(bmp_waddr) + 1'b1));

  // R8: live position only moves in retrace
  a_r8_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !retrace |=> ($stable(live_x) && $stable(live_y)));

  // R8: retrace copies the shadow set
  a_r8_live_copy: assert property (@(posedge clk) disable iff (!rst_n)
    retrace |=> (live_x == $past(shadow_x) && live_y == $past(shadow_y)));

  // R9: exactly one colour component is pending
  a_r9_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  // R9: a colour write always moves the component pointer
  a_r9_phase_moves: assert property (@(posedge clk) disable iff (!rst_n)
    cdata_wr |=> !$stable(phase) || $past(phase[2]));

endmodule

// File: rtl/cursor_bitmap.sv
module cursor_bitmap #(
  parameter int CUR_DIM = 64
) (
  input  logic                                  clk,
  input  logic                                  wr_en,
  input  logic                                  wr_plane,
  input  logic [$clog2(CUR_DIM*CUR_DIM/8)-1:0]  wr_addr,
  input  logic [7:0]                            wr_data,
  input  logic [$clog2(CUR_DIM)-1:0]            rd_row,
  input  logic [$clog2(CUR_DIM)-1:0]            rd_col,
  output logic                                  mask_bit,
  output logic                                  tog_bit
);
  localparam int BYTES   = CUR_DIM * CUR_DIM / 8;
  localparam int BADDR_W = $clog2(BYTES);
  localparam int COL_W   = $clog2(CUR_DIM);

  logic [BADDR_W-1:0] rd_idx;
  logic [2:0]         rd_bit;
  logic [1:0]         plane_bits;

  // rows are power-of-two bytes wide, so the byte index is a concatenation
  assign rd_idx = {rd_row, rd_col[COL_W-1:3]};
  assign rd_bit = 3'd7 - rd_col[2:0];

  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [7:0] mem [BYTES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_plane == p[0])) mem[wr_addr] <= wr_data;
    end
    assign plane_bits[p] = mem[rd_idx][rd_bit];
  end

  assign mask_bit = plane_bits[0];
  assign tog_bit  = plane_bits[1];

endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CUR_DIM = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cur_en,
  input  logic [COORD_W-1:0]         live_x,
  input  logic [COORD_W-1:0]         live_y,
  input  logic [COORD_W-1:0]         pix_x,
  input  logic [COORD_W-1:0]         pix_y,
  input  logic [23:0]                pix_rgb,
  input  rgb_t                       col_a,
  input  rgb_t                       col_b,
  input  logic                       mask_bit,
  input  logic                       tog_bit,
  output logic [$clog2(CUR_DIM)-1:0] rd_row,
  output logic [$clog2(CUR_DIM)-1:0] rd_col,
  output logic [23:0]                out_rgb
);
  localparam int REL_W = COORD_W + 2;
  localparam int COL_W = $clog2(CUR_DIM);
  localparam logic signed [REL_W-1:0] DIM_S = REL_W'(CUR_DIM);

  // offset of a raster coordinate inside the cursor square
  function automatic logic signed [REL_W-1:0] rel(
    input logic [COORD_W-1:0] p, input logic [COORD_W-1:0] base);
    return $signed({2'b00, p}) + DIM_S - $signed({2'b00, base});
  endfunction

  logic signed [REL_W-1:0] rx, ry;
  logic                    in_win;
  logic                    hit;
  pix_kind_e               kind;
  logic [23:0]             nxt_rgb;

  assign rx     = rel(pix_x, live_x);
  assign ry     = rel(pix_y, live_y);
  assign in_win = (rx >= 0) && (rx < DIM_S) && (ry >= 0) && (ry < DIM_S);
  assign hit    = cur_en && in_win;
  assign rd_col = rx[COL_W-1:0];
  assign rd_row = ry[COL_W-1:0];
  assign kind   = decode_pix(mask_bit, tog_bit);

  always_comb begin
    nxt_rgb = pix_rgb;
    if (hit) begin
      case (kind)
        PIX_INVERT: nxt_rgb = ~pix_rgb;
        PIX_COL0:   nxt_rgb = col_a;
        PIX_COL1:   nxt_rgb = col_b;
        default:    nxt_rgb = pix_rgb;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_rgb <= '0;
    else        out_rgb <= nxt_rgb;
  end

  // R2/R3: no cursor hit means the screen pixel one cycle later
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> out_rgb == $past(pix_rgb));

  // R5: an invert cell yields the complement of the screen pixel
  a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mask_bit && tog_bit) |=> out_rgb == ~$past(pix_rgb));

  // R5: colour cells yield the stored slot, independent of the screen
  a_r5_colour0: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mask_bit && !tog_bit) |=> out_rgb == $past(col_a));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CUR_DIM = 64,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [3:0]         host_sel,
  input  logic [7:0]         host_wdata,
  input  logic               retrace,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [23:0]        pix_rgb,
  output logic [23:0]        out_rgb
);
  localparam int BMP_BYTES = CUR_DIM * CUR_DIM / 8;
  localparam int BADDR_W   = $clog2(BMP_BYTES);
  localparam int COL_W     = $clog2(CUR_DIM);

  logic               cur_en, plane_sel, bmp_we;
  logic [BADDR_W-1:0] bmp_waddr;
  logic [7:0]         bmp_wdata;
  rgb_t               col_a, col_b;
  logic [COORD_W-1:0] live_x, live_y;
  logic [COL_W-1:0]   rd_row, rd_col;
  logic               mask_bit, tog_bit;

  cursor_regs #(.COORD_W(COORD_W), .BADDR_W(BADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .sel(host_sel), .wdata(host_wdata),
    .retrace(retrace), .cur_en(cur_en), .plane_sel(plane_sel),
    .bmp_we(bmp_we), .bmp_waddr(bmp_waddr), .bmp_wdata(bmp_wdata),
    .col_a(col_a), .col_b(col_b), .live_x(live_x), .live_y(live_y)
  );

  cursor_bitmap #(.CUR_DIM(CUR_DIM)) u_bitmap (
    .clk(clk), .wr_en(bmp_we), .wr_plane(plane_sel), .wr_addr(bmp_waddr),
    .wr_data(bmp_wdata), .rd_row(rd_row), .rd_col(rd_col),
    .mask_bit(mask_bit), .tog_bit(tog_bit)
  );

  cursor_mix #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) u_mix (
    .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .live_x(live_x), .live_y(live_y),
    .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb), .col_a(col_a), .col_b(col_b),
    .mask_bit(mask_bit), .tog_bit(tog_bit), .rd_row(rd_row), .rd_col(rd_col),
    .out_rgb(out_rgb)
  );

endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
  localparam int DIM   = 16;
  localparam int CW    = 10;
  localparam int BYTES = DIM * DIM / 8;
  localparam int FRAME = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [3:0]    host_sel = '0;
  logic [7:0]    host_wdata = '0;
  logic          retrace = 1'b0;
  logic [CW-1:0] pix_x = '0, pix_y = '0;
  logic [23:0]   pix_rgb = '0;
  logic [23:0]   out_rgb;

  int tests = 0, fails = 0;

  // bench model state
  logic [7:0]  m_and [BYTES];
  logic [7:0]  m_xor [BYTES];
  logic [23:0] m_c0 = '0, m_c1 = '0;
  logic        m_en = 1'b0;
  int          m_x = 0, m_y = 0;

  always #2 clk = ~clk;

  cursor_overlay #(.CUR_DIM(DIM), .COORD_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .retrace(retrace), .pix_x(pix_x), .pix_y(pix_y),
    .pix_rgb(pix_rgb), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] pat(int x, int y);
    return {8'(x * 3 + y), 8'(y * 5 + 1), 8'(x ^ (y << 2))};
  endfunction

  function automatic logic [23:0] model(int x, int y);
    int dx, dy, idx;
    logic a, t;
    if (!m_en) return pat(x, y);
    dx = x + DIM - m_x;
    dy = y + DIM - m_y;
    if (dx < 0 || dx >= DIM || dy < 0 || dy >= DIM) return pat(x, y);
    idx = dy * (DIM / 8) + dx / 8;
    a = m_and[idx][7 - dx % 8];
    t = m_xor[idx][7 - dx % 8];
    if (a && !t) return pat(x, y);
    if (a && t)  return ~pat(x, y);
    return t ? m_c1 : m_c0;
  endfunction

  task automatic wr(input int sel, input int data);
    host_we = 1'b1; host_sel = 4'(sel); host_wdata = 8'(data);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse_retrace();
    retrace = 1'b1;
    @(negedge clk);
    retrace = 1'b0;
  endtask

  task automatic set_pos(input int x, input int y);
    wr(6, x & 255); wr(7, x >> 8); wr(8, y & 255); wr(9, y >> 8);
  endtask

  task automatic sweep(input string tag);
    int bad;
    bad = 0;
    for (int y = 0; y < FRAME; y++) begin
      for (int x = 0; x < FRAME; x++) begin
        logic [23:0] exp_v;
        pix_x = CW'(x); pix_y = CW'(y); pix_rgb = pat(x, y);
        @(negedge clk);
        exp_v = model(x, y);
        tests++;
        if (out_rgb !== exp_v) begin
          fails++;
          if (bad < 8) $display("FAIL %s at x=%0d y=%0d: got %h expected %h",
                                tag, x, y, out_rgb, exp_v);
          bad++;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, cursor off, pure one-cycle pass-through
    sweep("R1");

    // R6/R7: mask plane (ctrl bit1 = 0), full plane plus wrap to byte 0
    wr(3, 0); wr(0, 0); wr(1, 0);
    for (int i = 0; i < BYTES; i++) begin
      m_and[i] = 8'(i * 37 + 11);
      wr(2, m_and[i]);
    end
    m_and[0] = 8'hA5;            // R6: address wrapped after last byte
    wr(2, 8'hA5);
    // toggle plane (ctrl bit1 = 1)
    wr(3, 2); wr(0, 0); wr(1, 0);
    for (int i = 0; i < BYTES; i++) begin
      m_xor[i] = 8'(i * 91 + 5);
      wr(2, m_xor[i]);
    end

    // R9: colours R,G,B per slot, slot wraps 2 -> 0
    wr(4, 0);
    wr(5, 8'h11); wr(5, 8'h22); wr(5, 8'h33);
    wr(5, 8'h44); wr(5, 8'h55); wr(5, 8'h66);
    wr(5, 8'h77); wr(5, 8'h88); wr(5, 8'h99);
    wr(5, 8'hC1); wr(5, 8'hC2); wr(5, 8'hC3);
    m_c0 = 24'hC1C2C3; m_c1 = 24'h445566;

    // R2: loaded but still disabled
    sweep("R2");

    // R8: shadow write without retrace keeps live at (0,0): nothing shown
    set_pos(5, 10);
    wr(3, 1); m_en = 1'b1;
    sweep("R8");

    // R4: retrace applies position; cursor clipped top-left
    pulse_retrace(); m_x = 5; m_y = 10;
    sweep("R4");

    set_pos(16, 16); pulse_retrace(); m_x = 16; m_y = 16;
    sweep("R4");

    // R5: fully visible cursor, all four decodes
    set_pos(24, 20); pulse_retrace(); m_x = 24; m_y = 20;
    sweep("R5");

    // R3: cursor past the right edge of the swept area
    set_pos(50, 40); pulse_retrace(); m_x = 50; m_y = 40;
    sweep("R3");

    // R10: unused selects change nothing
    set_pos(24, 20); pulse_retrace(); m_x = 24; m_y = 20;
    for (int s = 10; s < 16; s++) wr(s, 8'hFF);
    sweep("R10");

    // R9: explicit slot select, out-of-range slot maps to 0
    wr(4, 1); wr(5, 8'h0A); wr(5, 8'h0B); wr(5, 8'h0C); m_c1 = 24'h0A0B0C;
    wr(4, 3); wr(5, 8'hD1); wr(5, 8'hD2); wr(5, 8'hD3); m_c0 = 24'hD1D2D3;
    sweep("R9");

    // R7: plane steering mid-stream; R6: address set through the port
    wr(3, 1); wr(0, 10); wr(1, 0);
    wr(2, 8'h0F); m_and[10] = 8'h0F;
    wr(3, 3); wr(0, 11);
    wr(2, 8'hF0); m_xor[11] = 8'hF0;
    wr(2, 8'h3C); m_xor[12] = 8'h3C;
    sweep("R7");

    // R2: disable again
    wr(3, 0); m_en = 1'b0;
    sweep("R2");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule